// File: doc/BRIEF.md
# Peripheral Access Firewall Filter

This block sits in front of a set of peripherals and decides, for every transaction aimed at one of them, whether it may proceed. Each transaction carries a peripheral index and three attributes: a security flag (secure or non-secure), a privilege flag (privileged or unprivileged) and a 3-bit compartment number. The block compares these attributes with configuration held for the addressed peripheral. It returns a registered grant or deny verdict one clock after it samples the request.

Configuration lives in three groups, all reached through a plain write port. The first is a security bitmap and the second is a privilege bitmap. Each bitmap packs 32 peripherals per 32-bit word. The third group is one compartment register per peripheral, which selects one of three modes: no compartment filtering, a single static owner, or semaphore mode. In semaphore mode a whitelist of compartments replaces the static owner, and the requester must also hold the peripheral's semaphore. A companion block tracks that semaphore and reports ownership of the current request on an input. Only secure, privileged configuration writes reach the registers. At reset every register is zero, which leaves every peripheral open.

Top module: `periph_access_filter`

## Requirements
- R1: While reset is held and after it is released, `dec_valid`, `dec_grant` and `dec_deny` are low until a request arrives. With all configuration at its reset value of zero, every request to an index below `NUM_PERIPH` is granted, whatever its attributes.
- R2: A request sampled with `req_valid` high at a rising edge produces `dec_valid` high after that edge, together with exactly one of `dec_grant` or `dec_deny`. A cycle without a request produces all three outputs low.
- R3: A request whose index is `NUM_PERIPH` or more is denied.
- R4: The security bit of peripheral i is bit (i mod 32) of the word at byte address 0x10 + 4·(i div 32). When that bit is 1, a non-secure request to i is denied and a secure one passes this check.
- R5: The privilege bit of peripheral i is bit (i mod 32) of the word at byte address 0x30 + 4·(i div 32). When that bit is 1, an unprivileged request to i is denied. When it is 0, both privilege levels pass.
- R6: The compartment register of peripheral i is at byte address 0x100 + 8·i. Bit 0 enables compartment filtering, bit 1 selects semaphore mode, bits 6:4 hold the static owner and bits 23:16 hold the whitelist, with bit 16+c standing for compartment c. When bit 0 is 0, the compartment number of a request does not affect the verdict.
- R7: With filtering on and semaphore mode off, a static owner of 0 lets every compartment pass. Any other owner value lets only a request with an equal compartment number pass.
- R8: With filtering and semaphore mode both on, the static owner is ignored. A request passes only if its whitelist bit is 1 and `req_sem_held` is high.
- R9: A configuration write takes effect only when `cfg_sec` and `cfg_priv` are both high. Any other write leaves every verdict unchanged.
- R10: A configuration write affects requests sampled at later edges. A request sampled at the same edge as the write is judged on the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Byte address of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_sec | input | 1 | Configuration write is secure |
| cfg_priv | input | 1 | Configuration write is privileged |
| req_valid | input | 1 | A transaction is presented this cycle |
| req_idx | input | IDX_W | Target peripheral index |
| req_sec | input | 1 | Transaction is secure |
| req_priv | input | 1 | Transaction is privileged |
| req_cid | input | 3 | Compartment number of the requester |
| req_sem_held | input | 1 | Requester currently holds the target's semaphore |
| dec_valid | output | 1 | A verdict is present |
| dec_grant | output | 1 | Verdict: access allowed |
| dec_deny | output | 1 | Verdict: access refused |

## Verification
Every configuration bit affects only the verdicts for its own peripheral. A wrongly stored or wrongly decoded bit therefore shows up as a flipped grant or deny on the first request to that peripheral whose attributes exercise that bit, one clock after the request. The bench reaches each check axis with directed cases. It also issues a long mix of random writes and requests, so a misplaced word index, field offset or write gate surfaces as a verdict mismatch within a few cycles of the faulty write. Verdict timing errors, such as an unregistered or doubly registered decision, show up on the very first request after reset.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
   localparam int CID_W       = 3;
   localparam int NUM_CID     = 1 << CID_W;
   localparam int CFG_W       = 32;
   localparam int WORD_BITS   = 32;
   localparam int SEC_BASE    = 'h10;
   localparam int PRIV_BASE   = 'h30;
   localparam int CID_BASE    = 'h100;
   localparam int WORD_STRIDE = 4;
   localparam int CID_STRIDE  = 8;
   localparam int MAP_SPAN    = PRIV_BASE - SEC_BASE;
   // field positions inside a compartment register
   localparam int POS_FILT_EN = 0;
   localparam int POS_SEM_EN  = 1;
   localparam int POS_OWNER   = 4;
   localparam int POS_WLIST   = 16;

   typedef struct packed {
      logic [NUM_CID-1:0] wlist;
      logic [CID_W-1:0]   owner;
      logic               sem_en;
      logic               filt_en;
   } cid_cfg_t;

   function automatic cid_cfg_t to_cid_cfg(input logic [CFG_W-1:0] d);
      cid_cfg_t c;
      c.filt_en = d[POS_FILT_EN];
      c.sem_en  = d[POS_SEM_EN];
      c.owner   = d[POS_OWNER +: CID_W];
      c.wlist   = d[POS_WLIST +: NUM_CID];
      return c;
   endfunction
endpackage

// File: rtl/pfw_cfg_regs.sv
module pfw_cfg_regs
   import pfw_pkg::*;
#(
   parameter int NUM_PERIPH = 40,
   parameter int ADDR_W     = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [CFG_W-1:0]      wr_data,
   output logic [NUM_PERIPH-1:0] sec_map,
   output logic [NUM_PERIPH-1:0] priv_map,
   output cid_cfg_t              cid_cfg [NUM_PERIPH]
);
   localparam int NUM_WORDS = (NUM_PERIPH + WORD_BITS - 1) / WORD_BITS;

   logic [NUM_WORDS-1:0] sec_word_hit;
   logic [NUM_WORDS-1:0] priv_word_hit;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign sec_word_hit[w]  = wr_en && (wr_addr == ADDR_W'(SEC_BASE  + WORD_STRIDE * w));
      assign priv_word_hit[w] = wr_en && (wr_addr == ADDR_W'(PRIV_BASE + WORD_STRIDE * w));
   end

   for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
      localparam int WI = i / WORD_BITS;
      localparam int BI = i % WORD_BITS;
      logic     sec_q;
      logic     priv_q;
      cid_cfg_t cfg_q;
      logic     cid_hit;

      assign cid_hit = wr_en && (wr_addr == ADDR_W'(CID_BASE + CID_STRIDE * i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sec_q  <= 1'b0;
            priv_q <= 1'b0;
            cfg_q  <= '0;
         end else begin
            if (sec_word_hit[WI])  sec_q  <= wr_data[BI];
            if (priv_word_hit[WI]) priv_q <= wr_data[BI];
            if (cid_hit)           cfg_q  <= to_cid_cfg(wr_data);
         end
      end

      assign sec_map[i]  = sec_q;
      assign priv_map[i] = priv_q;
      assign cid_cfg[i]  = cfg_q;
   end
endmodule

// File: rtl/pfw_cid_check.sv
module pfw_cid_check
   import pfw_pkg::*;
(
   input  cid_cfg_t         cfg,
   input  logic [CID_W-1:0] cid,
   input  logic             sem_held,
   output logic             pass
);
   always_comb begin
      if (!cfg.filt_en) begin
         pass = 1'b1;
      end else if (cfg.sem_en) begin
         pass = cfg.wlist[cid] && sem_held;
      end else begin
         pass = (cfg.owner == '0) || (cfg.owner == cid);
      end
   end
endmodule

// File: rtl/pfw_decide.sv
module pfw_decide (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic in_range,
   input  logic sec_ok,
   input  logic priv_ok,
   input  logic cid_ok,
   output logic dec_valid,
   output logic dec_grant,
   output logic dec_deny
);
   logic all_ok;
   assign all_ok = in_range && sec_ok && priv_ok && cid_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_grant <= 1'b0;
         dec_deny  <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         dec_grant <= req_valid && all_ok;
         dec_deny  <= req_valid && !all_ok;
      end
   end
endmodule

// File: rtl/periph_access_filter.sv
module periph_access_filter
   import pfw_pkg::*;
#(
   parameter int NUM_PERIPH = 40,
   parameter int IDX_W      = 6,
   parameter int ADDR_W     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              cfg_sec,
   input  logic              cfg_priv,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic              req_sec,
   input  logic              req_priv,
   input  logic [2:0]        req_cid,
   input  logic              req_sem_held,
   output logic              dec_valid,
   output logic              dec_grant,
   output logic              dec_deny
);
   localparam int SEL_W     = $clog2(NUM_PERIPH);
   localparam int NUM_WORDS = (NUM_PERIPH + WORD_BITS - 1) / WORD_BITS;

   if (NUM_PERIPH < 2 || NUM_WORDS * WORD_STRIDE > MAP_SPAN) begin : g_bad_count
      $error("NUM_PERIPH out of supported range");
   end
   if (IDX_W < SEL_W || IDX_W > 30) begin : g_bad_idx
      $error("IDX_W cannot address NUM_PERIPH entries");
   end
   if (CID_BASE + CID_STRIDE * NUM_PERIPH > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the compartment registers");
   end

   logic                  cfg_wr_ok;
   logic [NUM_PERIPH-1:0] sec_map;
   logic [NUM_PERIPH-1:0] priv_map;
   cid_cfg_t              cid_cfg [NUM_PERIPH];
   logic                  in_range;
   logic [SEL_W-1:0]      sel;
   cid_cfg_t              sel_cfg;
   logic                  sec_ok;
   logic                  priv_ok;
   logic                  cid_ok;

   assign cfg_wr_ok = cfg_we && cfg_sec && cfg_priv;

   pfw_cfg_regs #(
      .NUM_PERIPH (NUM_PERIPH),
      .ADDR_W     (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_ok),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .sec_map  (sec_map),
      .priv_map (priv_map),
      .cid_cfg  (cid_cfg)
   );

   assign in_range = {1'b0, req_idx} < (IDX_W + 1)'(NUM_PERIPH);
   assign sel      = in_range ? req_idx[SEL_W-1:0] : '0;
   assign sel_cfg  = cid_cfg[sel];
   assign sec_ok   = req_sec  || !sec_map[sel];
   assign priv_ok  = req_priv || !priv_map[sel];

   pfw_cid_check u_cid (
      .cfg      (sel_cfg),
      .cid      (req_cid),
      .sem_held (req_sem_held),
      .pass     (cid_ok)
   );

   pfw_decide u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .in_range  (in_range),
      .sec_ok    (sec_ok),
      .priv_ok   (priv_ok),
      .cid_ok    (cid_ok),
      .dec_valid (dec_valid),
      .dec_grant (dec_grant),
      .dec_deny  (dec_deny)
   );
endmodule

// File: rtl/pfw_checker.sv
module pfw_checker #(
   parameter int NUM_PERIPH = 40,
   parameter int SEL_W      = 6
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_we,
   input logic                  cfg_sec,
   input logic                  cfg_priv,
   input logic                  req_valid,
   input logic                  req_sec,
   input logic                  req_priv,
   input logic                  in_range,
   input logic [SEL_W-1:0]      sel,
   input logic [NUM_PERIPH-1:0] sec_map,
   input logic [NUM_PERIPH-1:0] priv_map,
   input logic                  dec_valid,
   input logic                  dec_grant,
   input logic                  dec_deny
);
   p_verdict_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid && !dec_grant && !dec_deny);

   p_single_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $onehot({dec_grant, dec_deny}));

   p_range_deny_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !in_range |=> dec_deny);

   p_nonsec_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && in_range && sec_map[sel] && !req_sec |=> dec_deny);

   p_unpriv_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && in_range && priv_map[sel] && !req_priv |=> dec_deny);

   p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !(cfg_sec && cfg_priv) |=> $stable(sec_map) && $stable(priv_map));
endmodule

bind periph_access_filter pfw_checker #(
   .NUM_PERIPH (NUM_PERIPH),
   .SEL_W      (SEL_W)
) u_pfw_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sec   (cfg_sec),
   .cfg_priv  (cfg_priv),
   .req_valid (req_valid),
   .req_sec   (req_sec),
   .req_priv  (req_priv),
   .in_range  (in_range),
   .sel       (sel),
   .sec_map   (sec_map),
   .priv_map  (priv_map),
   .dec_valid (dec_valid),
   .dec_grant (dec_grant),
   .dec_deny  (dec_deny)
);

// File: tb/test_periph_access_filter.sv
module test_periph_access_filter;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 40;
   localparam int IW = 6;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          cfg_sec = 1'b0;
   logic          cfg_priv = 1'b0;
   logic          req_valid = 1'b0;
   logic [IW-1:0] req_idx = '0;
   logic          req_sec = 1'b0;
   logic          req_priv = 1'b0;
   logic [2:0]    req_cid = '0;
   logic          req_sem_held = 1'b0;
   logic          dec_valid;
   logic          dec_grant;
   logic          dec_deny;

   int vectors = 0;
   int misses = 0;

   bit       m_sec   [NP];
   bit       m_priv  [NP];
   bit       m_filt  [NP];
   bit       m_sem   [NP];
   int       m_owner [NP];
   bit [7:0] m_wl    [NP];

   always #(CLK_PERIOD / 2) clk = ~clk;

   periph_access_filter #(.NUM_PERIPH(NP), .IDX_W(IW), .ADDR_W(AW)) i_periph_access_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_sec(cfg_sec), .cfg_priv(cfg_priv), .req_valid(req_valid), .req_idx(req_idx),
      .req_sec(req_sec), .req_priv(req_priv), .req_cid(req_cid), .req_sem_held(req_sem_held),
      .dec_valid(dec_valid), .dec_grant(dec_grant), .dec_deny(dec_deny));

   function automatic bit model_grant(int idx, bit s, bit p, int cid, bit sem);
      if (idx >= NP) return 1'b0;
      if (m_sec[idx] && !s) return 1'b0;
      if (m_priv[idx] && !p) return 1'b0;
      if (m_filt[idx]) begin
         if (m_sem[idx]) return m_wl[idx][cid] && sem;
         if (m_owner[idx] != 0 && m_owner[idx] != cid) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic void model_write(int a, bit [31:0] d);
      if (a >= 'h10 && a < 'h18 && a % 4 == 0) begin
         for (int b = 0; b < 32; b++) begin
            int k = (a - 'h10) / 4 * 32 + b;
            if (k < NP) m_sec[k] = d[b];
         end
      end
      if (a >= 'h30 && a < 'h38 && a % 4 == 0) begin
         for (int b = 0; b < 32; b++) begin
            int k = (a - 'h30) / 4 * 32 + b;
            if (k < NP) m_priv[k] = d[b];
         end
      end
      if (a >= 'h100 && (a - 'h100) % 8 == 0 && (a - 'h100) / 8 < NP) begin
         int k = (a - 'h100) / 8;
         m_filt[k]  = d[0];
         m_sem[k]   = d[1];
         m_owner[k] = int'(d[6:4]);
         m_wl[k]    = d[23:16];
      end
   endfunction

   function automatic bit [31:0] cid_word(bit filt, bit sem, int owner, bit [7:0] wl);
      bit [2:0] o = owner[2:0];
      return {8'h00, wl, 9'h000, o, 2'b00, sem, filt};
   endfunction

   task automatic compare(string tag, bit ev, bit eg);
      vectors++;
      if (dec_valid !== ev || dec_grant !== eg || dec_deny !== (ev && !eg)) begin
         misses++;
         $display("FAIL %s: got valid=%b grant=%b deny=%b, expected valid=%b grant=%b deny=%b",
                  tag, dec_valid, dec_grant, dec_deny, ev, eg, ev && !eg);
      end
   endtask

   // one clock: drive at the falling edge, compare after the next falling edge
   task automatic cycle(string tag, bit v, int idx, bit s, bit p, int cid, bit sem,
                        bit we, int a, bit [31:0] d, bit ws, bit wp);
      bit eg;
      req_valid = v; req_idx = idx[IW-1:0]; req_sec = s; req_priv = p;
      req_cid = cid[2:0]; req_sem_held = sem;
      cfg_we = we; cfg_addr = a[AW-1:0]; cfg_wdata = d; cfg_sec = ws; cfg_priv = wp;
      eg = v && model_grant(idx, s, p, cid, sem);
      @(posedge clk);
      if (we && ws && wp) model_write(a, d);
      @(negedge clk);
      compare(tag, v, eg);
   endtask

   task automatic req(string tag, int idx, bit s, bit p, int cid, bit sem);
      cycle(tag, 1'b1, idx, s, p, cid, sem, 1'b0, 0, 32'h0, 1'b0, 1'b0);
   endtask

   task automatic wr(string tag, int a, bit [31:0] d, bit ws, bit wp);
      cycle(tag, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b1, a, d, ws, wp);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      misses++;
      $display("FAIL R2: watchdog expired, got no end of run, expected finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 during reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after release", 1'b0, 1'b0);

      // R1: everything open out of reset
      req("R1 open idx0", 0, 1'b0, 1'b0, 5, 1'b0);
      req("R1 open idx39", 39, 1'b0, 1'b0, 7, 1'b0);
      // R2: idle cycle gives no verdict
      wr("R2 idle", 'h7fc, 32'h0, 1'b0, 1'b0);
      // R3: out of range
      req("R3 idx40", 40, 1'b1, 1'b1, 0, 1'b1);
      req("R3 idx63", 63, 1'b1, 1'b1, 0, 1'b1);

      // R4: secure bit of peripheral 35 = word 1 bit 3
      wr("R4 set", 'h14, 32'h0000_0008, 1'b1, 1'b1);
      req("R4 nonsec 35", 35, 1'b0, 1'b1, 0, 1'b0);
      req("R4 sec 35", 35, 1'b1, 1'b0, 0, 1'b0);
      req("R4 nonsec 34", 34, 1'b0, 1'b0, 0, 1'b0);

      // R5: privilege bit of peripheral 7
      wr("R5 set", 'h30, 32'h0000_0080, 1'b1, 1'b1);
      req("R5 unpriv 7", 7, 1'b1, 1'b0, 0, 1'b0);
      req("R5 priv 7", 7, 1'b0, 1'b1, 0, 1'b0);
      req("R5 unpriv 6", 6, 1'b0, 1'b0, 0, 1'b0);

      // R6: filtering off, owner field has no effect
      wr("R6 set", 'h100 + 8 * 10, cid_word(1'b0, 1'b0, 3, 8'h00), 1'b1, 1'b1);
      req("R6 cid4", 10, 1'b0, 1'b0, 4, 1'b0);
      req("R6 cid3", 10, 1'b0, 1'b0, 3, 1'b0);

      // R7: static owner
      wr("R7 owner3", 'h100 + 8 * 10, cid_word(1'b1, 1'b0, 3, 8'h00), 1'b1, 1'b1);
      req("R7 match", 10, 1'b0, 1'b0, 3, 1'b0);
      req("R7 mismatch", 10, 1'b0, 1'b0, 4, 1'b0);
      wr("R7 owner0", 'h100 + 8 * 10, cid_word(1'b1, 1'b0, 0, 8'h00), 1'b1, 1'b1);
      req("R7 wildcard", 10, 1'b0, 1'b0, 6, 1'b0);

      // R8: semaphore mode, whitelist holds compartment 2 only, owner 5 ignored
      wr("R8 set", 'h100 + 8 * 20, cid_word(1'b1, 1'b1, 5, 8'h04), 1'b1, 1'b1);
      req("R8 listed holder", 20, 1'b0, 1'b0, 2, 1'b1);
      req("R8 listed no sem", 20, 1'b0, 1'b0, 2, 1'b0);
      req("R8 owner unlisted", 20, 1'b0, 1'b0, 5, 1'b1);

      // R9: writes without both attributes are dropped
      wr("R9 nonsec write", 'h10, 32'hffff_ffff, 1'b0, 1'b1);
      req("R9 after nonsec write", 0, 1'b0, 1'b0, 0, 1'b0);
      wr("R9 unpriv write", 'h30, 32'hffff_ffff, 1'b1, 1'b0);
      req("R9 after unpriv write", 0, 1'b0, 1'b0, 0, 1'b0);
      wr("R9 unpriv cid write", 'h100 + 8 * 1, cid_word(1'b1, 1'b0, 7, 8'h00), 1'b1, 1'b0);
      req("R9 after cid write", 1, 1'b0, 1'b0, 2, 1'b0);

      // R10: same-edge write does not affect the request
      cycle("R10 same edge", 1'b1, 0, 1'b0, 1'b0, 0, 1'b0, 1'b1, 'h10, 32'h0000_0001, 1'b1, 1'b1);
      req("R10 next edge", 0, 1'b0, 1'b0, 0, 1'b0);

      // mixed random traffic against the model
      for (int k = 0; k < 600; k++) begin
         int  sel = int'($urandom % 6);
         int  a;
         bit [31:0] d;
         bit  we = ($urandom % 3) == 0;
         if (sel == 0)      begin a = 'h10 + 4 * int'($urandom % 2); d = $urandom & $urandom & $urandom; end
         else if (sel == 1) begin a = 'h30 + 4 * int'($urandom % 2); d = $urandom & $urandom & $urandom; end
         else if (sel == 5) begin a = int'($urandom % 4096); d = $urandom; end
         else               begin a = 'h100 + 8 * int'($urandom % NP); d = $urandom; end
         cycle("R2 mixed", ($urandom % 4) != 0, int'($urandom % 48), 1'($urandom), 1'($urandom),
               int'($urandom % 8), 1'($urandom), we, a, d, ($urandom % 4) != 0, ($urandom % 4) != 0);
      end

      summary();
      $finish;
   end
endmodule